// File: doc/BRIEF.md
# PID-Steered USB CRC Engine

This block sits in both bit streams of a USB serial engine, after the destuffer on the receive side and ahead of the stuffer on the transmit side. Every packet starts with its packet identifier (PID). The engine reads the two low type bits of the PID and picks one of three treatments: a 5-bit CRC for token and start-of-frame packets, a 16-bit CRC for data packets, or no CRC for handshake and special packets. The PID itself never enters a CRC.

On receive, the chosen CRC runs over every bit that follows the PID, including the CRC field the sender appended. When the packet ends, the raw register contents are pushed into the receive FIFO as two bytes. Software then only compares those bytes with a fixed residual. A pass flag reports the same comparison for direct observation. On transmit, the same CRC runs over the payload. When the upstream logic asks for the CRC field, an output multiplexer replaces the payload bit with the complemented register contents, most significant bit first. A length output tells the upstream logic how many CRC bits to request.

Top module: `usb_crc_engine`

## Requirements
- R1: The first 8 data-valid bits after a start pulse form the PID, taken least significant bit first. They never enter either CRC, so two packets that differ only in the PID upper bits give the same remainder.
- R2: The PID type bits {bit1, bit0} select the CRC. 2'b01 selects CRC-5 (x^5+x^2+1), 2'b11 selects CRC-16 (x^16+x^15+x^2+1), and 2'b10 or 2'b00 select no CRC.
- R3: One cycle after the cycle in which `rx_eop_i` is sampled, `rx_fifo_push_o` is high with the remainder bits [7:0]. The cycle after that, it is high with bits [15:0]'s upper byte [15:8]. A CRC-5 remainder is zero-extended to 16 bits.
- R4: For a CRC-5 packet, `rx_pass_o` is 1 exactly when the final 5-bit remainder equals 5'b01100.
- R5: For a CRC-16 packet, `rx_pass_o` is 1 exactly when the final remainder equals 16'h800D.
- R6: Both CRC registers are preset to all ones at each start pulse, so a packet's result does not depend on earlier packets.
- R7: On transmit, `tx_bit_o` equals `tx_bit_i` except when `tx_crc_i` is high for a CRC-carrying packet. In that case it emits the one's complement of the CRC register, most significant bit first, one bit per valid strobe.
- R8: After the transmit PID, `tx_crc_len_o` reads 5 for CRC-5, 16 for CRC-16 and 0 for no CRC.
- R9: Only cycles with the data-valid strobe high advance the CRC; bits presented with the strobe low have no effect on the remainder.
- R10: For a no-CRC packet, end of packet gives `rx_done_o` with `rx_pass_o` = 1 and no FIFO push.
- R11: After reset, no push, `rx_done_o` = 0, `rx_pass_o` = 0 and `tx_crc_len_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_sop_i | input | 1 | Receive start-of-packet pulse, before the first PID bit |
| rx_valid_i | input | 1 | Receive data-valid strobe from the destuffer |
| rx_bit_i | input | 1 | Receive data bit |
| rx_eop_i | input | 1 | Receive end-of-packet pulse |
| rx_fifo_push_o | output | 1 | Push strobe toward the receive FIFO |
| rx_fifo_data_o | output | 8 | Remainder byte, low byte first |
| rx_done_o | output | 1 | One-cycle pulse after end of packet |
| rx_pass_o | output | 1 | Remainder matches the residual (held until next packet end) |
| tx_sop_i | input | 1 | Transmit start-of-packet pulse |
| tx_valid_i | input | 1 | Transmit bit strobe |
| tx_bit_i | input | 1 | Transmit payload bit |
| tx_crc_i | input | 1 | Request for a CRC bit instead of payload |
| tx_bit_o | output | 1 | Multiplexed bit toward the stuffer |
| tx_crc_len_o | output | 5 | Number of CRC bits for the current packet |

## Verification
The hardest case to reach from the ports is showing that the PID is excluded from the CRC. A correct residual alone does not prove it, because a design that hashed the PID would still look self-consistent on its own output. To expose this, the stimulus sends the same deliberately wrong body under two PIDs of the same type. The two remainders must then match each other and a model that skips the PID. A second hard case is showing that unstrobed bits are ignored. For this, receive packets are interleaved with cycles that carry the inverted bit with the strobe low.

// File: rtl/usb_crc_pkg.sv
package usb_crc_pkg;
  localparam int unsigned PID_BITS  = 8;
  localparam int unsigned NUM_LANES = 2;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_C5   = 2'd1,
    KIND_C16  = 2'd2
  } crc_kind_e;

  function automatic int unsigned lane_width(input int unsigned i);
    return (i == 0) ? 5 : 16;
  endfunction

  function automatic logic [15:0] lane_poly(input int unsigned i);
    return (i == 0) ? 16'h0005 : 16'h8005;
  endfunction

  function automatic logic [15:0] lane_residual(input int unsigned i);
    return (i == 0) ? 16'h000C : 16'h800D;
  endfunction

  function automatic crc_kind_e lane_kind(input int unsigned i);
    return (i == 0) ? KIND_C5 : KIND_C16;
  endfunction

  function automatic crc_kind_e decode_type(input logic [1:0] t);
    case (t)
      2'b01:   return KIND_C5;
      2'b11:   return KIND_C16;
      default: return KIND_NONE;
    endcase
  endfunction
endpackage

// File: rtl/usb_crc_lane.sv
module usb_crc_lane #(
  parameter int unsigned W    = 5,
  parameter logic [15:0] POLY = 16'h0005
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         step_i,
  input  logic         bit_i,
  input  logic         shift_i,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] rem_q, rem_step;
  logic         fb;

  always_comb begin
    fb       = bit_i ^ rem_q[W-1];
    rem_step = {rem_q[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rem_q <= '1;
    else if (init_i)  rem_q <= '1;
    else if (step_i)  rem_q <= rem_step;
    else if (shift_i) rem_q <= {rem_q[W-2:0], 1'b1};
  end

  assign rem_o = rem_q;

  // R9: no strobe, no change
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !step_i && !shift_i) |=> $stable(rem_q));
  a_r6_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (rem_q == '1));
endmodule

// File: rtl/usb_pid_track.sv
module usb_pid_track
  import usb_crc_pkg::*;
#(
  parameter int unsigned NBITS = PID_BITS
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sop_i,
  input  logic      valid_i,
  input  logic      bit_i,
  output crc_kind_e kind_o,
  output logic      body_o
);
  localparam int unsigned CW = $clog2(NBITS + 1);

  logic [CW-1:0] cnt_q;
  logic          t0_q;
  crc_kind_e     kind_q;

  assign body_o = (cnt_q == CW'(NBITS));
  assign kind_o = kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      t0_q   <= 1'b0;
      kind_q <= KIND_NONE;
    end else if (sop_i) begin
      cnt_q  <= '0;
      kind_q <= KIND_NONE;
    end else if (valid_i && !body_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0) t0_q <= bit_i;
      if (cnt_q == CW'(1)) kind_q <= decode_type({bit_i, t0_q});
    end
  end

  // R2: type is fixed once the PID is complete
  a_r2_kind_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (body_o && !sop_i) |=> $stable(kind_q));
endmodule

// File: rtl/usb_crc_rx.sv
module usb_crc_rx
  import usb_crc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sop_i,
  input  logic       valid_i,
  input  logic       bit_i,
  input  logic       eop_i,
  output logic       push_o,
  output logic [7:0] data_o,
  output logic       done_o,
  output logic       pass_o
);
  crc_kind_e              kind;
  logic                   body;
  logic [15:0]            rem [NUM_LANES];
  logic [NUM_LANES-1:0]   hit;
  logic [15:0]            rem_sel;
  logic                   pass_now;
  logic                   push_q, done_q, pass_q, hi_pend_q;
  logic [7:0]             data_q, hi_q;

  usb_pid_track u_pid (
    .clk_i, .rst_ni, .sop_i, .valid_i, .bit_i,
    .kind_o(kind), .body_o(body)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned LW  = lane_width(g);
    localparam logic [15:0] LP  = lane_poly(g);
    localparam logic [15:0] RES = lane_residual(g);
    logic [LW-1:0] r;
    usb_crc_lane #(.W(LW), .POLY(LP)) u_lane (
      .clk_i, .rst_ni,
      .init_i (sop_i),
      .step_i (valid_i && body && kind == lane_kind(g)),
      .bit_i,
      .shift_i(1'b0),
      .rem_o  (r)
    );
    assign rem[g] = 16'(r);
    assign hit[g] = (kind == lane_kind(g)) && (r == RES[LW-1:0]);
  end

  always_comb begin
    rem_sel = '0;
    for (int i = 0; i < NUM_LANES; i++)
      if (kind == lane_kind(i)) rem_sel = rem[i];
    pass_now = (kind == KIND_NONE) || (|hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_q <= 1'b0; done_q <= 1'b0; pass_q <= 1'b0; hi_pend_q <= 1'b0;
      data_q <= '0;   hi_q   <= '0;
    end else begin
      done_q <= eop_i;
      if (eop_i) begin
        push_q    <= (kind != KIND_NONE);
        hi_pend_q <= (kind != KIND_NONE);
        data_q    <= rem_sel[7:0];
        hi_q      <= rem_sel[15:8];
        pass_q    <= pass_now;
      end else begin
        push_q    <= hi_pend_q;
        hi_pend_q <= 1'b0;
        data_q    <= hi_q;
      end
    end
  end

  assign push_o = push_q;
  assign data_o = data_q;
  assign done_o = done_q;
  assign pass_o = pass_q;

  a_r3_done_after_eop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(eop_i));
  a_r3_byte_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_q && done_q && !eop_i) |=> (push_q && !done_q));
  a_r10_bypass_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_i && kind == KIND_NONE) |=> !push_q);
endmodule

// File: rtl/usb_crc_tx.sv
module usb_crc_tx
  import usb_crc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sop_i,
  input  logic       valid_i,
  input  logic       bit_i,
  input  logic       crc_i,
  output logic       bit_o,
  output logic [4:0] crc_len_o
);
  crc_kind_e            kind;
  logic                 body;
  logic [NUM_LANES-1:0] msb;
  logic                 msb_sel;

  usb_pid_track u_pid (
    .clk_i, .rst_ni, .sop_i,
    .valid_i(valid_i && !crc_i),
    .bit_i,
    .kind_o (kind), .body_o(body)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned LW = lane_width(g);
    localparam logic [15:0] LP = lane_poly(g);
    logic [LW-1:0] r;
    usb_crc_lane #(.W(LW), .POLY(LP)) u_lane (
      .clk_i, .rst_ni,
      .init_i (sop_i),
      .step_i (valid_i && !crc_i && body && kind == lane_kind(g)),
      .bit_i,
      .shift_i(valid_i && crc_i && kind == lane_kind(g)),
      .rem_o  (r)
    );
    assign msb[g] = r[LW-1];
  end

  always_comb begin
    msb_sel   = 1'b0;
    crc_len_o = '0;
    for (int i = 0; i < NUM_LANES; i++)
      if (kind == lane_kind(i)) begin
        msb_sel   = msb[i];
        crc_len_o = 5'(lane_width(i));
      end
    bit_o = (crc_i && kind != KIND_NONE) ? ~msb_sel : bit_i;
  end
endmodule

// File: rtl/usb_crc_engine.sv
module usb_crc_engine (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_sop_i,
  input  logic       rx_valid_i,
  input  logic       rx_bit_i,
  input  logic       rx_eop_i,
  output logic       rx_fifo_push_o,
  output logic [7:0] rx_fifo_data_o,
  output logic       rx_done_o,
  output logic       rx_pass_o,
  input  logic       tx_sop_i,
  input  logic       tx_valid_i,
  input  logic       tx_bit_i,
  input  logic       tx_crc_i,
  output logic       tx_bit_o,
  output logic [4:0] tx_crc_len_o
);
  usb_crc_rx u_rx (
    .clk_i, .rst_ni,
    .sop_i  (rx_sop_i),
    .valid_i(rx_valid_i),
    .bit_i  (rx_bit_i),
    .eop_i  (rx_eop_i),
    .push_o (rx_fifo_push_o),
    .data_o (rx_fifo_data_o),
    .done_o (rx_done_o),
    .pass_o (rx_pass_o)
  );

  usb_crc_tx u_tx (
    .clk_i, .rst_ni,
    .sop_i    (tx_sop_i),
    .valid_i  (tx_valid_i),
    .bit_i    (tx_bit_i),
    .crc_i    (tx_crc_i),
    .bit_o    (tx_bit_o),
    .crc_len_o(tx_crc_len_o)
  );
endmodule

// File: tb/tb_usb_crc_engine.sv
module tb_usb_crc_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic rx_sop = 0, rx_valid = 0, rx_bit = 0, rx_eop = 0;
  logic tx_sop = 0, tx_valid = 0, tx_bit = 0, tx_crc = 0;
  logic rx_fifo_push, rx_done, rx_pass, tx_bit_o;
  logic [7:0] rx_fifo_data;
  logic [4:0] tx_crc_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_crc_engine dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_sop_i(rx_sop), .rx_valid_i(rx_valid), .rx_bit_i(rx_bit), .rx_eop_i(rx_eop),
    .rx_fifo_push_o(rx_fifo_push), .rx_fifo_data_o(rx_fifo_data),
    .rx_done_o(rx_done), .rx_pass_o(rx_pass),
    .tx_sop_i(tx_sop), .tx_valid_i(tx_valid), .tx_bit_i(tx_bit), .tx_crc_i(tx_crc),
    .tx_bit_o(tx_bit_o), .tx_crc_len_o(tx_crc_len)
  );

  int n_chk = 0, n_bad = 0, n_push = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pkt [0:255];
  int         plen;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_fifo_push) begin
      n_push++;
      if (exp_q.size() == 0) chk("R10 unexpected push", 1, 0);
      else chk(tag_q.pop_front(), rx_fifo_data, exp_q.pop_front());
    end
  end

  function automatic logic [15:0] model(input int from, input int to, input int w);
    logic [15:0] c, poly, mask;
    logic fb;
    mask = (w == 5) ? 16'h001F : 16'hFFFF;
    poly = (w == 5) ? 16'h0005 : 16'h8005;
    c = mask;
    for (int i = from; i < to; i++) begin
      fb = pkt[i] ^ c[w-1];
      c = (c << 1) & mask;
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  task automatic clr(); plen = 0; endtask

  task automatic add_val(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin pkt[plen] = v[i]; plen++; end
  endtask

  task automatic add_crc(input int w);
    logic [15:0] c;
    c = model(8, plen, w);
    for (int i = w - 1; i >= 0; i--) begin pkt[plen] = ~c[i]; plen++; end
  endtask

  function automatic int kind_w();
    case ({pkt[1], pkt[0]})
      2'b01:   return 5;
      2'b11:   return 16;
      default: return 0;
    endcase
  endfunction

  task automatic rx_send(input string tag, input bit gaps,
                         output logic [15:0] rem, output logic pass);
    int w;
    w = kind_w();
    @(negedge clk) rx_sop = 1;
    @(negedge clk) rx_sop = 0;
    for (int i = 0; i < plen; i++) begin
      if (gaps && (i % 3 == 1)) begin
        rx_valid = 0; rx_bit = ~pkt[i];
        @(negedge clk);
      end
      rx_valid = 1; rx_bit = pkt[i];
      @(negedge clk);
    end
    rx_valid = 0; rx_eop = 1;
    rem = 16'h0; pass = 1'b1;
    if (w > 0) begin
      rem  = model(8, plen, w);
      pass = (rem == ((w == 5) ? 16'h000C : 16'h800D));
      exp_q.push_back(rem[7:0]);  tag_q.push_back({tag, " R3 low byte"});
      exp_q.push_back(rem[15:8]); tag_q.push_back({tag, " R3 high byte"});
    end
    @(negedge clk) rx_eop = 0;
    chk({tag, " R3 done pulse"}, rx_done, 1);
    chk({tag, " R4/R5 pass flag"}, rx_pass, pass);
    @(negedge clk);
    @(negedge clk);
    chk({tag, " R3 queue drained"}, exp_q.size(), 0);
  endtask

  task automatic tx_send(input string tag);
    int w, mism;
    logic [15:0] c;
    w = kind_w();
    c = model(8, plen, w);
    mism = 0;
    @(negedge clk) tx_sop = 1;
    @(negedge clk) tx_sop = 0;
    for (int i = 0; i < plen; i++) begin
      tx_valid = 1; tx_bit = pkt[i]; tx_crc = 0;
      #1 if (tx_bit_o !== pkt[i]) mism++;
      @(negedge clk);
    end
    tx_valid = 0;
    #1 chk({tag, " R8 crc length"}, tx_crc_len, w);
    for (int i = w - 1; i >= 0; i--) begin
      @(negedge clk);
      tx_valid = 1; tx_crc = 1; tx_bit = 0;
      #1 if (tx_bit_o !== ~c[i]) mism++;
    end
    if (w == 0) begin
      @(negedge clk);
      tx_crc = 1; tx_bit = 1;
      #1 if (tx_bit_o !== 1'b1) mism++;
    end
    @(negedge clk);
    tx_valid = 0; tx_crc = 0;
    chk({tag, " R7 output bit mismatches"}, mism, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rem_a, rem_b, rem;
    logic pass;
    int np;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset push", rx_fifo_push, 0);
    chk("R11 reset done", rx_done, 0);
    chk("R11 reset pass", rx_pass, 0);
    chk("R11 reset tx len", tx_crc_len, 0);

    // R4: good token, CRC-5
    clr(); add_val(8'hE1, 8); add_val(11'h3A5, 11); add_crc(5);
    rx_send("tok", 0, rem, pass);
    chk("R4 token residual", rem, 16'h000C);
    chk("R4 token pass", rx_pass, 1);
    chk("R2 token high byte zero-extended", rem[15:5], 0);

    // R1: same wrong body under two token PIDs
    clr(); add_val(8'hE1, 8); add_val(16'hBEEF, 16);
    rx_send("R1 pidA", 0, rem_a, pass);
    clr(); add_val(8'h69, 8); add_val(16'hBEEF, 16);
    rx_send("R1 pidB", 0, rem_b, pass);
    chk("R1 pid excluded: remainders equal", rem_a, rem_b);

    // R4: corrupted token
    clr(); add_val(8'hE1, 8); add_val(11'h3A5, 11); add_crc(5);
    pkt[12] = ~pkt[12];
    rx_send("tok bad", 0, rem, pass);
    chk("R4 corrupted token fails", rx_pass, 0);

    // R5 + R9: data packet with unstrobed inverted bits interleaved
    clr(); add_val(8'hC3, 8); add_val(16'h1234, 16); add_val(16'hA55A, 16); add_crc(16);
    rx_send("R9 data gaps", 1, rem, pass);
    chk("R5 data residual", rem, 16'h800D);
    chk("R9 data pass with gaps", rx_pass, 1);

    // R5: corrupted data
    clr(); add_val(8'hC3, 8); add_val(16'h00FF, 16); add_crc(16);
    pkt[20] = ~pkt[20];
    rx_send("data bad", 0, rem, pass);
    chk("R5 corrupted data fails", rx_pass, 0);

    // R6: empty data packet right after a failing one
    clr(); add_val(8'h4B, 8); add_crc(16);
    rx_send("R6 empty data", 0, rem, pass);
    chk("R6 empty data pass", rx_pass, 1);

    // R10: handshake, no pushes
    np = n_push;
    clr(); add_val(8'hD2, 8);
    rx_send("R10 ack", 0, rem, pass);
    chk("R10 ack pass", rx_pass, 1);
    clr(); add_val(8'h5A, 8); add_val(16'hFACE, 16);
    rx_send("R10 handshake trailing", 0, rem, pass);
    clr(); add_val(8'h3C, 8); add_val(16'h0F0F, 16);
    rx_send("R2 special type 00", 0, rem, pass);
    chk("R10 R2 no push for bypass", n_push - np, 0);

    // transmit
    clr(); add_val(8'hE1, 8); add_val(11'h2C1, 11);
    tx_send("R7 tx token");
    clr(); add_val(8'hC3, 8); add_val(16'hC0DE, 16); add_val(8'h7E, 8);
    tx_send("R7 tx data");
    clr(); add_val(8'hD2, 8);
    tx_send("R7 tx ack");

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule